// File: doc/BRIEF.md
# Boot-Mode Global Chip-Select Decoder

This block drives chip-select 0 of an external memory controller. Out of reset it sits in a boot mode where any access leaving the chip selects the boot memory, whatever its address. A boot ROM can therefore be fetched from before software has programmed anything. The port size used in that mode comes from the reset configuration, so the ROM can be placed anywhere in the address space.

Software first loads base register 0 with the wanted range and then writes option register 0. That write permanently leaves boot mode, and chip-select 0 then decodes only the masked base range. Boot mode returns only through a reset. The block also presents the bank's port size and wait-state count alongside the chip-select, for a downstream transfer sequencer.

Top module: `bootcs_decoder`

## Requirements
- R1: After reset the block is in boot mode, the option wait field reads all ones (15 for a 4-bit field), the address mask is all zeros, base register 0 is valid with a zero base and no write protection, and its port size equals `cfg_ps`.
- R2: In boot mode, with `acc_req` high and `acc_internal` low, `cs0_o` is 1 for every page value and for both reads and writes, and `ps_o` equals `cfg_ps`; with `acc_req` low `cs0_o` is 0.
- R3: When `acc_internal` is 1, `cs0_o` is 0 in either mode.
- R4: When `cfg_flash_boot` is 1, `cs0_o` stays 0 for the whole of boot mode.
- R5: A write with `wr_en`=1 and `wr_opt`=1 (option register 0) ends boot mode from the following cycle; an access presented in the same cycle as that write is still decoded in boot mode.
- R6: Once boot mode has ended, further option-register writes do not restore it; only reset does.
- R7: In normal mode an access hits when `(acc_page & mask) == (base & mask)` and the valid bit is 1; otherwise `cs0_o` is 0.
- R8: In normal mode a set write-protect bit suppresses `cs0_o` for writes (`acc_write`=1) and leaves reads alone; in boot mode write protection has no effect.
- R9: `wait_o` always shows the option register's wait field, and in normal mode `ps_o` shows the base register's port-size field.
- R10: Writes to base register 0 (`wr_opt`=0) take effect in the registers but do not end boot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ps | input | 2 | Port size from the reset configuration |
| cfg_flash_boot | input | 1 | 1 = boot from internal flash, chip-select 0 silent in boot mode |
| wr_en | input | 1 | Register write strobe |
| wr_opt | input | 1 | 1 = option register 0, 0 = base register 0 |
| wr_addr | input | MASK_W | Base page (base write) or address mask (option write) |
| wr_ps | input | 2 | Port size, base write only |
| wr_wp | input | 1 | Write protect, base write only |
| wr_valid | input | 1 | Valid bit, base write only |
| wr_wait | input | WAIT_W | Wait-state count, option write only |
| acc_req | input | 1 | Access request |
| acc_page | input | MASK_W | Upper address bits of the access |
| acc_write | input | 1 | 1 = write access |
| acc_internal | input | 1 | 1 = access targets an on-chip register |
| cs0_o | output | 1 | Chip-select 0 |
| ps_o | output | 2 | Port size of the selected bank |
| wait_o | output | WAIT_W | Wait-state count of the selected bank |

## Verification
The bench builds the decoder with an 8-bit page field and a 4-bit wait field. With only 256 pages, single mask patterns such as 0xC0 and 0xF0 split the space into a few obvious hit and miss regions, so hits, misses and the mask change across a second option write all land on chosen page values. The narrow wait field keeps the reset value of all ones easy to tell apart from programmed counts.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    typedef enum logic {
        GCS_NORMAL = 1'b0,
        GCS_BOOT   = 1'b1
    } gcs_mode_e;

    typedef logic [1:0] gcs_ps_t;

    // Write protection only bites on write accesses.
    function automatic logic gcs_wp_block(input logic wp, input logic is_write);
        return wp & is_write;
    endfunction

endpackage

// File: rtl/gcs_regs.sv
module gcs_regs
    import gcs_pkg::*;
#(
    parameter int MASK_W = 17,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  gcs_ps_t           cfg_ps,
    input  logic              wr_en,
    input  logic              wr_opt,
    input  logic [MASK_W-1:0] wr_addr,
    input  gcs_ps_t           wr_ps,
    input  logic              wr_wp,
    input  logic              wr_valid,
    input  logic [WAIT_W-1:0] wr_wait,
    output gcs_mode_e         mode,
    output logic [MASK_W-1:0] base_page,
    output gcs_ps_t           base_ps,
    output logic              base_wp,
    output logic              base_valid,
    output logic [MASK_W-1:0] opt_mask,
    output logic [WAIT_W-1:0] opt_wait
);

    typedef struct packed {
        logic [MASK_W-1:0] page;
        gcs_ps_t           ps;
        logic              wp;
        logic              valid;
    } base_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [WAIT_W-1:0] wcnt;
    } opt_t;

    localparam logic [WAIT_W-1:0] WAIT_RST = {WAIT_W{1'b1}};

    base_t     base_q;
    opt_t      opt_q;
    gcs_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '{page: '0, ps: cfg_ps, wp: 1'b0, valid: 1'b1};
            opt_q  <= '{mask: '0, wcnt: WAIT_RST};
            mode_q <= GCS_BOOT;
        end else if (wr_en) begin
            if (wr_opt) begin
                opt_q  <= '{mask: wr_addr, wcnt: wr_wait};
                mode_q <= GCS_NORMAL;
            end else begin
                base_q <= '{page: wr_addr, ps: wr_ps, wp: wr_wp, valid: wr_valid};
            end
        end
    end

    assign mode       = mode_q;
    assign base_page  = base_q.page;
    assign base_ps    = base_q.ps;
    assign base_wp    = base_q.wp;
    assign base_valid = base_q.valid;
    assign opt_mask   = opt_q.mask;
    assign opt_wait   = opt_q.wcnt;

    AST_BOOT_ONEWAY: assert property (@(posedge clk) disable iff (rst)
        mode_q == GCS_NORMAL |=> mode_q == GCS_NORMAL); // R6
    AST_BOOT_EXIT: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_opt |=> mode_q == GCS_NORMAL); // R5
    AST_BASE_KEEPS_BOOT: assert property (@(posedge clk) disable iff (rst)
        mode_q == GCS_BOOT && !(wr_en && wr_opt) |=> mode_q == GCS_BOOT); // R10

endmodule

// File: rtl/gcs_match.sv
module gcs_match
    import gcs_pkg::*;
#(
    parameter int MASK_W = 17
) (
    input  logic [MASK_W-1:0] page,
    input  logic [MASK_W-1:0] base_page,
    input  logic [MASK_W-1:0] mask,
    input  logic              valid,
    input  logic              wp,
    input  logic              is_write,
    output logic              hit
);

    logic [MASK_W-1:0] diff;

    always_comb begin
        diff = (page ^ base_page) & mask;
        hit  = valid && (diff == '0) && !gcs_wp_block(wp, is_write);
    end

endmodule

// File: rtl/bootcs_decoder.sv
module bootcs_decoder
    import gcs_pkg::*;
#(
    parameter int MASK_W = 17,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_ps,
    input  logic              cfg_flash_boot,
    input  logic              wr_en,
    input  logic              wr_opt,
    input  logic [MASK_W-1:0] wr_addr,
    input  logic [1:0]        wr_ps,
    input  logic              wr_wp,
    input  logic              wr_valid,
    input  logic [WAIT_W-1:0] wr_wait,
    input  logic              acc_req,
    input  logic [MASK_W-1:0] acc_page,
    input  logic              acc_write,
    input  logic              acc_internal,
    output logic              cs0_o,
    output logic [1:0]        ps_o,
    output logic [WAIT_W-1:0] wait_o
);

    gcs_mode_e         mode;
    logic [MASK_W-1:0] base_page;
    gcs_ps_t           base_ps;
    logic              base_wp;
    logic              base_valid;
    logic [MASK_W-1:0] opt_mask;
    logic [WAIT_W-1:0] opt_wait;
    logic              norm_hit;
    logic              boot_hit;
    logic              external;

    gcs_regs #(.MASK_W(MASK_W), .WAIT_W(WAIT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_ps     (cfg_ps),
        .wr_en      (wr_en),
        .wr_opt     (wr_opt),
        .wr_addr    (wr_addr),
        .wr_ps      (wr_ps),
        .wr_wp      (wr_wp),
        .wr_valid   (wr_valid),
        .wr_wait    (wr_wait),
        .mode       (mode),
        .base_page  (base_page),
        .base_ps    (base_ps),
        .base_wp    (base_wp),
        .base_valid (base_valid),
        .opt_mask   (opt_mask),
        .opt_wait   (opt_wait)
    );

    gcs_match #(.MASK_W(MASK_W)) u_match (
        .page      (acc_page),
        .base_page (base_page),
        .mask      (opt_mask),
        .valid     (base_valid),
        .wp        (base_wp),
        .is_write  (acc_write),
        .hit       (norm_hit)
    );

    always_comb begin
        external = acc_req && !acc_internal;
        boot_hit = !cfg_flash_boot;
        if (mode == GCS_BOOT) begin
            cs0_o = external && boot_hit;
            ps_o  = cfg_ps;
        end else begin
            cs0_o = external && norm_hit;
            ps_o  = base_ps;
        end
        wait_o = opt_wait;
    end

    AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        acc_internal |-> !cs0_o); // R3
    AST_FLASH_BOOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode == GCS_BOOT && cfg_flash_boot |-> !cs0_o); // R4
    AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        mode == GCS_NORMAL && base_wp && acc_write |-> !cs0_o); // R8

endmodule

// File: tb/bootcs_decoder_test.sv
module bootcs_decoder_test;

    localparam int MW = 8;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    cfg_ps;
    logic          cfg_flash_boot;
    logic          wr_en, wr_opt, wr_wp, wr_valid;
    logic [MW-1:0] wr_addr;
    logic [1:0]    wr_ps;
    logic [WW-1:0] wr_wait;
    logic          acc_req, acc_write, acc_internal;
    logic [MW-1:0] acc_page;
    logic          cs0_o;
    logic [1:0]    ps_o;
    logic [WW-1:0] wait_o;

    always #5 clk = ~clk;

    bootcs_decoder #(.MASK_W(MW), .WAIT_W(WW)) uut (
        .clk(clk), .rst(rst), .cfg_ps(cfg_ps), .cfg_flash_boot(cfg_flash_boot),
        .wr_en(wr_en), .wr_opt(wr_opt), .wr_addr(wr_addr), .wr_ps(wr_ps),
        .wr_wp(wr_wp), .wr_valid(wr_valid), .wr_wait(wr_wait),
        .acc_req(acc_req), .acc_page(acc_page), .acc_write(acc_write),
        .acc_internal(acc_internal), .cs0_o(cs0_o), .ps_o(ps_o), .wait_o(wait_o)
    );

    typedef struct {
        logic          cs;
        logic [1:0]    ps;
        logic [WW-1:0] wt;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference model state
    logic          m_boot, m_valid, m_wp;
    logic [MW-1:0] m_base, m_mask;
    logic [1:0]    m_ps;
    logic [WW-1:0] m_wait;

    task automatic do_reset(input logic [1:0] ps, input logic flash);
        @(negedge clk);
        rst = 1'b1; cfg_ps = ps; cfg_flash_boot = flash;
        wr_en = 1'b0; acc_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_boot = 1'b1; m_valid = 1'b1; m_wp = 1'b0;
        m_base = '0; m_mask = '0; m_ps = ps; m_wait = '1;
    endtask

    task automatic step(input logic we, input logic wopt, input logic [MW-1:0] wa,
                        input logic [1:0] wps, input logic wwp, input logic wval,
                        input logic [WW-1:0] wwt, input logic req,
                        input logic [MW-1:0] pg, input logic wr, input logic intl,
                        input string tag);
        exp_t e;
        if (step_count > 0) @(negedge clk);
        step_count++;
        wr_en = we; wr_opt = wopt; wr_addr = wa; wr_ps = wps; wr_wp = wwp;
        wr_valid = wval; wr_wait = wwt;
        acc_req = req; acc_page = pg; acc_write = wr; acc_internal = intl;
        if (!req || intl)  e.cs = 1'b0;
        else if (m_boot)   e.cs = !cfg_flash_boot;
        else               e.cs = m_valid && ((pg & m_mask) == (m_base & m_mask)) && !(m_wp && wr);
        e.ps  = m_boot ? cfg_ps : m_ps;
        e.wt  = m_wait;
        e.tag = tag;
        exp_q.push_back(e);
        if (we) begin
            if (wopt) begin m_mask = wa; m_wait = wwt; m_boot = 1'b0; end
            else begin m_base = wa; m_ps = wps; m_wp = wwp; m_valid = wval; end
        end
    endtask

    int step_count = 0;

    task automatic acc(input logic [MW-1:0] pg, input logic wr, input logic intl, input string tag);
        step(1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, '0, 1'b1, pg, wr, intl, tag);
    endtask

    // monitor: compares outputs mid-cycle against the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cs0_o !== e.cs || ps_o !== e.ps || wait_o !== e.wt) begin
                    errors++;
                    $display("FAIL %s actual cs=%b ps=%b wait=%h expected cs=%b ps=%b wait=%h",
                             e.tag, cs0_o, ps_o, wait_o, e.cs, e.ps, e.wt);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wr_en = 0; wr_opt = 0; wr_addr = '0; wr_ps = '0; wr_wp = 0; wr_valid = 0;
        wr_wait = '0; acc_req = 0; acc_page = '0; acc_write = 0; acc_internal = 0;
        rst = 1'b1; cfg_ps = 2'b10; cfg_flash_boot = 1'b0;
        do_reset(2'b10, 1'b0);
        acc(8'h00, 1'b0, 1'b0, "R1 reset state boot read page 00");
        acc(8'hFF, 1'b1, 1'b0, "R2 boot write page FF");
        step(1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, '0, 1'b0, 8'h12, 1'b0, 1'b0, "R2 no request");
        acc(8'h33, 1'b0, 1'b1, "R3 internal in boot");
        // base write: page 40, ps 01, write protect, valid
        step(1'b1, 1'b0, 8'h40, 2'b01, 1'b1, 1'b1, '0, 1'b1, 8'h13, 1'b0, 1'b0, "R10 base write cycle");
        acc(8'h99, 1'b1, 1'b0, "R10 R8 boot kept, wp ignored");
        // option write: mask C0 wait 3, same-cycle access
        step(1'b1, 1'b1, 8'hC0, 2'b00, 1'b0, 1'b0, 4'd3, 1'b1, 8'h00, 1'b0, 1'b0, "R5 same-cycle boot decode");
        acc(8'h41, 1'b0, 1'b0, "R7 R9 normal hit");
        acc(8'h80, 1'b0, 1'b0, "R7 normal miss");
        acc(8'h7F, 1'b1, 1'b0, "R8 wp blocks write");
        acc(8'h7F, 1'b0, 1'b0, "R8 wp allows read");
        acc(8'h7F, 1'b0, 1'b1, "R3 internal in normal");
        step(1'b1, 1'b1, 8'hF0, 2'b00, 1'b0, 1'b0, 4'd5, 1'b1, 8'h45, 1'b0, 1'b0, "R6 second option write old mask");
        acc(8'h55, 1'b0, 1'b0, "R6 still normal after rewrite");
        acc(8'h45, 1'b0, 1'b0, "R9 new wait value");
        step(1'b1, 1'b0, 8'h40, 2'b11, 1'b0, 1'b0, '0, 1'b0, 8'h00, 1'b0, 1'b0, "R7 clear valid");
        acc(8'h41, 1'b0, 1'b0, "R7 invalid bank silent");
        step(1'b1, 1'b0, 8'h40, 2'b11, 1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 base ps 11");
        acc(8'h41, 1'b1, 1'b0, "R8 R9 write hit without wp");
        // flash boot
        do_reset(2'b01, 1'b1);
        step_count = 0;
        acc(8'h20, 1'b0, 1'b0, "R4 flash boot silent");
        acc(8'hE7, 1'b1, 1'b0, "R4 R1 flash boot write");
        step(1'b1, 1'b1, 8'h00, 2'b00, 1'b0, 1'b0, 4'd2, 1'b1, 8'h20, 1'b0, 1'b0, "R4 still silent on exit cycle");
        acc(8'hE7, 1'b0, 1'b0, "R1 reset base matches with zero mask");
        // reset restores boot
        do_reset(2'b01, 1'b0);
        step_count = 0;
        acc(8'h5A, 1'b1, 1'b0, "R6 reset restores boot");
        @(negedge clk);
        #5;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule